// File: doc/BRIEF.md
# Crosstalk-Safe Bus Encoder and Decoder

This block protects a wide on-chip bus against its worst coupling case, in which one wire switches in the opposite direction to both of its neighbours. It does this by never letting a lone bit sit between two opposite bits on the wires. The encoder turns a 16-bit data word into a 26-wire word. Along that word, no three adjacent wires ever read 010 or 101. The decoder at the far end turns the wire word back into the data word.

The data word is split into 4-bit nibbles. Each nibble maps on its own to a 5-bit codeword that is free of both patterns. Between neighbouring codewords sit two junction wires. The first repeats the last bit of the lower codeword. The second repeats the first bit of the upper codeword. With this layout, no group ever depends on another group, so logic depth does not grow with bus width. The decoder ignores the junction wires. If a 5-bit field is not a legal codeword, the decoder flags that group. Each side has a valid-qualified input and output and an optional output register, chosen by parameter.

Top module: `xt_bus_codec`

## Requirements
- R1: While the encoder output is valid, no three adjacent wires of `enc_wire_o` (bits i, i+1, i+2 for i = 0..23) read 010 or 101.
- R2: Nibble g of the data (bits 4g+3..4g) with value k drives wires 7g+4..7g. The value placed there is the k-th pattern-free 5-bit word in ascending numeric order: 0,1,3,6,7,12,14,15,16,17,19,24,25,28,30,31.
- R3: For each junction between group g and group g+1, wire 7g+5 equals wire 7g+4 and wire 7g+6 equals wire 7g+7.
- R4: For any decoder input whose four fields are legal codewords, `dec_data_o` returns the inverse of the R2 map for every nibble, whatever the junction wires carry.
- R5: A field that is not one of the 16 legal words sets `dec_err_o[g]` and forces nibble g of `dec_data_o` to zero. Legal fields in the same word still decode normally.
- R6: With `ENC_REG=1` the encoder's valid and wires appear one clock after the input; with `DEC_REG=1` the decoder's valid, data and flags appear one clock after its input. A value of 0 makes the side combinational.
- R7: A synchronous active-low reset clears both registered valid outputs and all error flags in the next clock edge.
- R8: `dec_err_o` is all zero whenever `dec_vld_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_vld_i | input | 1 | Encoder input valid |
| enc_data_i | input | 16 | Data word to encode |
| enc_vld_o | output | 1 | Encoder output valid |
| enc_wire_o | output | 26 | Pattern-free wire word |
| dec_vld_i | input | 1 | Decoder input valid |
| dec_wire_i | input | 26 | Received wire word |
| dec_vld_o | output | 1 | Decoder output valid |
| dec_data_o | output | 16 | Recovered data word |
| dec_err_o | output | 4 | Per-group illegal-codeword flag |

## Verification
With both sides registered, an encoder input driven between edges shows on the wires at the next sampling point, one clock later. The decoder result for the same word follows one clock after that when the wires loop back to the decoder. A behavioural model in the bench holds, for each side, the value that is due at the coming sampling point. It compares that value on every clock at the falling edge, so a result that comes a cycle early or late is caught as a mismatch. All 65536 data words pass through the loop, with idle cycles mixed in. A second phase drives the decoder directly with corrupted junction wires and illegal fields.

// File: rtl/xt_pkg.sv
// Shared sizes and code functions for the crosstalk-safe bus codec.
// Assumes a fixed 4-bit nibble and a 5-bit codeword per group.
package xt_pkg;

    localparam int NIB_W   = 4;
    localparam int CW_W    = 5;
    localparam int JCT_W   = 2;
    localparam int SLICE_W = CW_W + JCT_W;

    // True when no 3-bit window of the word holds a lone bit between opposites
    function automatic logic cw_legal(input logic [CW_W-1:0] w);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < CW_W - 2; i++) begin
            if ((w[i] != w[i+1]) && (w[i+1] != w[i+2])) ok = 1'b0;
        end
        return ok;
    endfunction

    // Map a nibble to the nibble-th legal codeword in ascending order
    function automatic logic [CW_W-1:0] cw_of_nib(input logic [NIB_W-1:0] n);
        logic [CW_W-1:0] res;
        int k;
        res = '0;
        k   = 0;
        for (int v = 0; v < (1 << CW_W); v++) begin
            if (cw_legal(CW_W'(v))) begin
                if (k == int'(n)) res = CW_W'(v);
                k++;
            end
        end
        return res;
    endfunction

    // Inverse map: the rank of a legal codeword among the legal words
    function automatic logic [NIB_W-1:0] nib_of_cw(input logic [CW_W-1:0] w);
        int k;
        k = 0;
        for (int v = 0; v < (1 << CW_W); v++) begin
            if ((v < int'(w)) && cw_legal(CW_W'(v))) k++;
        end
        return NIB_W'(k);
    endfunction

endpackage

// File: rtl/xt_grp_enc.sv
// One group encoder: nibble in, pattern-free 5-bit codeword out.
// Purely combinational; assumes nothing about neighbouring groups.
module xt_grp_enc
    import xt_pkg::*;
(
    input  logic [NIB_W-1:0] nib_i,
    output logic [CW_W-1:0]  cw_o
);

    // Look the codeword up from the ordered legal set
    always_comb begin
        cw_o = cw_of_nib(nib_i);
    end

endmodule

// File: rtl/xt_grp_dec.sv
// One group decoder: 5-bit field in, nibble and illegal flag out.
// An illegal field yields a zero nibble; assumes a valid qualifier elsewhere.
module xt_grp_dec
    import xt_pkg::*;
(
    input  logic [CW_W-1:0]  cw_i,
    output logic [NIB_W-1:0] nib_o,
    output logic             bad_o
);

    // Classify the field and invert the map when it is legal
    always_comb begin
        bad_o = !cw_legal(cw_i);
        nib_o = bad_o ? '0 : nib_of_cw(cw_i);
    end

endmodule

// File: rtl/xt_stage.sv
// Optional output register with a matching valid bit.
// REG=1 adds one clock of latency with synchronous active-low reset; REG=0 is a wire.
module xt_stage #(
    parameter int W   = 8,
    parameter bit REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld_i,
    input  logic [W-1:0] d_i,
    output logic         vld_o,
    output logic [W-1:0] d_o
);

    if (REG) begin : g_reg
        // Capture valid and payload each clock, clear both on reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_o <= 1'b0;
                d_o   <= '0;
            end else begin
                vld_o <= vld_i;
                d_o   <= d_i;
            end
        end
    end else begin : g_thru
        // Pass straight through when no stage is wanted
        always_comb begin
            vld_o = vld_i;
            d_o   = d_i;
        end
    end

endmodule

// File: rtl/xt_bus_codec.sv
// Crosstalk-safe bus codec top: per-group encoders with junction wires,
// per-group decoders with illegal-field flags, optional output stages.
// Assumes decoder fields sit at the same wire positions the encoder uses.
module xt_bus_codec
    import xt_pkg::*;
#(
    parameter int GROUPS  = 4,
    parameter bit ENC_REG = 1'b1,
    parameter bit DEC_REG = 1'b1,
    localparam int DATA_W = NIB_W * GROUPS,
    localparam int WIRE_W = SLICE_W * GROUPS - JCT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_vld_i,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic              enc_vld_o,
    output logic [WIRE_W-1:0] enc_wire_o,
    input  logic              dec_vld_i,
    input  logic [WIRE_W-1:0] dec_wire_i,
    output logic              dec_vld_o,
    output logic [DATA_W-1:0] dec_data_o,
    output logic [GROUPS-1:0] dec_err_o
);

    localparam int DEC_PW = DATA_W + GROUPS;

    logic [CW_W-1:0]   enc_cw [GROUPS];
    logic [WIRE_W-1:0] wire_c;
    logic [DATA_W-1:0] data_c;
    logic [GROUPS-1:0] bad_c;
    logic [DEC_PW-1:0] dec_q;

    for (genvar g = 0; g < GROUPS; g++) begin : g_enc
        xt_grp_enc u_enc (
            .nib_i (enc_data_i[NIB_W*g +: NIB_W]),
            .cw_o  (enc_cw[g])
        );
        assign wire_c[SLICE_W*g +: CW_W] = enc_cw[g];
        if (g < GROUPS - 1) begin : g_jct
            // Junction wires echo the two facing codeword edges
            assign wire_c[SLICE_W*g + CW_W]     = enc_cw[g][CW_W-1];
            assign wire_c[SLICE_W*g + CW_W + 1] = enc_cw[g+1][0];
        end
    end

    xt_stage #(.W(WIRE_W), .REG(ENC_REG)) u_enc_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (enc_vld_i),
        .d_i   (wire_c),
        .vld_o (enc_vld_o),
        .d_o   (enc_wire_o)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_dec
        logic bad_raw;
        xt_grp_dec u_dec (
            .cw_i  (dec_wire_i[SLICE_W*g +: CW_W]),
            .nib_o (data_c[NIB_W*g +: NIB_W]),
            .bad_o (bad_raw)
        );
        // Flags only count while the received word is valid
        assign bad_c[g] = bad_raw & dec_vld_i;
    end

    xt_stage #(.W(DEC_PW), .REG(DEC_REG)) u_dec_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (dec_vld_i),
        .d_i   ({bad_c, data_c}),
        .vld_o (dec_vld_o),
        .d_o   (dec_q)
    );

    assign dec_data_o = dec_q[DATA_W-1:0];
    assign dec_err_o  = dec_q[DEC_PW-1:DATA_W];

endmodule

// File: rtl/xt_codec_chk.sv
// Property checker for xt_bus_codec, attached by bind below.
// Assumes the same parameters as the instance it watches.
module xt_codec_chk
    import xt_pkg::*;
#(
    parameter int GROUPS  = 4,
    parameter bit ENC_REG = 1'b1,
    parameter bit DEC_REG = 1'b1,
    localparam int DATA_W = NIB_W * GROUPS,
    localparam int WIRE_W = SLICE_W * GROUPS - JCT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enc_vld_i,
    input logic              enc_vld_o,
    input logic [WIRE_W-1:0] enc_wire_o,
    input logic              dec_vld_i,
    input logic              dec_vld_o,
    input logic [DATA_W-1:0] dec_data_o,
    input logic [GROUPS-1:0] dec_err_o
);

    logic armed;
    logic wire_bad;

    // Note whether the previous edge was already out of reset
    always_ff @(posedge clk) begin
        armed <= rst_n;
    end

    // Scan every window of three wires for a lone bit
    always_comb begin
        wire_bad = 1'b0;
        for (int i = 0; i < WIRE_W - 2; i++) begin
            if ((enc_wire_o[i] != enc_wire_o[i+1]) && (enc_wire_o[i+1] != enc_wire_o[i+2]))
                wire_bad = 1'b1;
        end
    end

    // R1
    no_lone_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_vld_o |-> !wire_bad);

    for (genvar g = 0; g < GROUPS - 1; g++) begin : g_jct
        // R3
        jct_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
            enc_vld_o |-> (enc_wire_o[SLICE_W*g + CW_W] == enc_wire_o[SLICE_W*g + CW_W - 1]) &&
                          (enc_wire_o[SLICE_W*g + CW_W + 1] == enc_wire_o[SLICE_W*(g+1)]));
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_err
        // R5
        bad_nib_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            dec_err_o[g] |-> (dec_data_o[NIB_W*g +: NIB_W] == '0));
    end

    // R8
    err_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|dec_err_o) |-> dec_vld_o);

    if (ENC_REG) begin : g_enc_lat
        // R6
        enc_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            armed |-> (enc_vld_o == $past(enc_vld_i)));
        // R7
        enc_rst_chk: assert property (@(posedge clk)
            !rst_n |=> !enc_vld_o);
    end

    if (DEC_REG) begin : g_dec_lat
        // R6
        dec_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            armed |-> (dec_vld_o == $past(dec_vld_i)));
        // R7
        dec_rst_chk: assert property (@(posedge clk)
            !rst_n |=> (!dec_vld_o && (dec_err_o == '0)));
    end

endmodule

bind xt_bus_codec xt_codec_chk #(
    .GROUPS  (GROUPS),
    .ENC_REG (ENC_REG),
    .DEC_REG (DEC_REG)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enc_vld_i  (enc_vld_i),
    .enc_vld_o  (enc_vld_o),
    .enc_wire_o (enc_wire_o),
    .dec_vld_i  (dec_vld_i),
    .dec_vld_o  (dec_vld_o),
    .dec_data_o (dec_data_o),
    .dec_err_o  (dec_err_o)
);

// File: tb/sim_xt_bus_codec.sv
// Bench: behavioural model of the requirements, compared at each falling edge.
module sim_xt_bus_codec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        e_vld = 1'b0;
    logic [15:0] e_in = '0;
    logic        enc_vld_o;
    logic [25:0] enc_wire_o;
    logic        inj_sel = 1'b0;
    logic        inj_vld = 1'b0;
    logic [25:0] inj_wire = '0;
    logic        dec_vld;
    logic [25:0] dec_wire;
    logic        dec_vld_o;
    logic [15:0] dec_data_o;
    logic [3:0]  dec_err_o;

    int checks = 0;
    int errors = 0;
    bit live = 1'b0;
    bit done = 1'b0;

    logic        x_enc_vld = 1'b0;
    logic [25:0] x_enc_wire = '0;
    logic        x_dec_vld = 1'b0;
    logic [15:0] x_dec_data = '0;
    logic [3:0]  x_dec_err = '0;
    bit          x_inj = 1'b0;

    always #2 clk = ~clk;

    assign dec_wire = inj_sel ? inj_wire : enc_wire_o;
    assign dec_vld  = inj_sel ? inj_vld  : enc_vld_o;

    xt_bus_codec #(.GROUPS(4), .ENC_REG(1'b1), .DEC_REG(1'b1)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .enc_vld_i  (e_vld),
        .enc_data_i (e_in),
        .enc_vld_o  (enc_vld_o),
        .enc_wire_o (enc_wire_o),
        .dec_vld_i  (dec_vld),
        .dec_wire_i (dec_wire),
        .dec_vld_o  (dec_vld_o),
        .dec_data_o (dec_data_o),
        .dec_err_o  (dec_err_o)
    );

    function automatic bit ok_bits(input logic [31:0] w, input int n);
        for (int i = 0; i + 2 < n; i++)
            if ((w[i] != w[i+1]) && (w[i+1] != w[i+2])) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [4:0] ref_code(input int n);
        int k = 0;
        for (int v = 0; v < 32; v++) begin
            if (ok_bits(32'(v), 5)) begin
                if (k == n) return 5'(v);
                k++;
            end
        end
        return '0;
    endfunction

    function automatic logic [25:0] ref_wire(input logic [15:0] d);
        logic [25:0] w = '0;
        logic [4:0]  c [4];
        for (int g = 0; g < 4; g++) c[g] = ref_code(int'(d[4*g +: 4]));
        for (int g = 0; g < 4; g++) begin
            w[7*g +: 5] = c[g];
            if (g < 3) begin
                w[7*g + 5] = c[g][4];
                w[7*g + 6] = c[g+1][0];
            end
        end
        return w;
    endfunction

    task automatic ref_dec(input logic [25:0] w, output logic [15:0] d, output logic [3:0] e);
        d = '0;
        e = '0;
        for (int g = 0; g < 4; g++) begin
            logic [4:0] f = w[7*g +: 5];
            if (!ok_bits(32'(f), 5)) e[g] = 1'b1;
            else begin
                int k = 0;
                for (int v = 0; v < int'(f); v++) if (ok_bits(32'(v), 5)) k++;
                d[4*g +: 4] = 4'(k);
            end
        end
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: compare what is due now, then drive the next stimulus
    task automatic step(input logic vld, input logic [15:0] d,
                        input logic isel, input logic ivld, input logic [25:0] iw);
        @(negedge clk);
        if (live) begin
            chk(enc_vld_o === x_enc_vld, "R6 enc valid", 32'(enc_vld_o), 32'(x_enc_vld));
            if (x_enc_vld) begin
                chk(enc_wire_o === x_enc_wire, "R2 wires", 32'(enc_wire_o), 32'(x_enc_wire));
                chk(ok_bits(32'(enc_wire_o), 26), "R1 lone bit", 32'(enc_wire_o), 32'(x_enc_wire));
                for (int g = 0; g < 3; g++)
                    chk((enc_wire_o[7*g+5] === enc_wire_o[7*g+4]) &&
                        (enc_wire_o[7*g+6] === enc_wire_o[7*g+7]),
                        "R3 junction", 32'(enc_wire_o), 32'(x_enc_wire));
            end
            chk(dec_vld_o === x_dec_vld, "R6 dec valid", 32'(dec_vld_o), 32'(x_dec_vld));
            if (x_dec_vld) begin
                chk(dec_data_o === x_dec_data, x_inj ? "R5 data" : "R4 data",
                    32'(dec_data_o), 32'(x_dec_data));
                chk(dec_err_o === x_dec_err, "R5 flags", 32'(dec_err_o), 32'(x_dec_err));
            end else begin
                chk(dec_err_o === 4'd0, "R8 flags idle", 32'(dec_err_o), 32'd0);
            end
        end
        // Decoder result due next: from what the decoder sees this cycle
        x_inj = isel;
        x_dec_vld = isel ? ivld : enc_vld_o;
        ref_dec(isel ? iw : enc_wire_o, x_dec_data, x_dec_err);
        e_vld = vld;
        e_in = d;
        inj_sel = isel;
        inj_vld = ivld;
        inj_wire = iw;
        x_enc_vld = vld;
        x_enc_wire = ref_wire(d);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        // R7: outputs idle while reset is held
        repeat (3) begin
            @(negedge clk);
            chk(enc_vld_o === 1'b0 && dec_vld_o === 1'b0, "R7 reset valid",
                32'({enc_vld_o, dec_vld_o}), 32'd0);
            chk(dec_err_o === 4'd0, "R7 reset flags", 32'(dec_err_o), 32'd0);
        end
        rst_n = 1'b1;
        live = 1'b1;

        // Full sweep through encoder and decoder, with idle gaps (R1..R4, R6, R8)
        for (int i = 0; i < 65536; i++) begin
            if ((i % 16) == 0) step(1'b0, 16'(~i), 1'b0, 1'b0, '0);
            step(1'b1, 16'(i), 1'b0, 1'b0, '0);
        end
        repeat (3) step(1'b0, '0, 1'b0, 1'b0, '0);

        // Direct decoder stimulus: junction noise and illegal fields (R4, R5)
        for (int t = 0; t < 64; t++) begin
            logic [25:0] w;
            w = ref_wire(16'($urandom));
            for (int g = 0; g < 3; g++) w[7*g+5 +: 2] = 2'($urandom);
            for (int g = 0; g < 4; g++) begin
                if (((t >> g) & 1) == 1) begin
                    int pick = int'($urandom % 16);
                    int k = 0;
                    for (int v = 0; v < 32; v++) begin
                        if (!ok_bits(32'(v), 5)) begin
                            if (k == pick) w[7*g +: 5] = 5'(v);
                            k++;
                        end
                    end
                end
            end
            step(1'b0, '0, 1'b1, (t % 5) != 4, w);
        end
        repeat (2) step(1'b0, '0, 1'b1, 1'b0, '0);

        // R7: reset in the middle of traffic clears the registered outputs
        step(1'b1, 16'h1234, 1'b1, 1'b1, 26'h0000155);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(enc_vld_o === 1'b0 && dec_vld_o === 1'b0, "R7 mid reset valid",
            32'({enc_vld_o, dec_vld_o}), 32'd0);
        chk(dec_err_o === 4'd0, "R7 mid reset flags", 32'(dec_err_o), 32'd0);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule